// File: doc/BRIEF.md
# CEC Signal Free Time Timer

This block measures how long a single-wire consumer-electronics control bus has stayed idle after a frame ends. A node must see that idle period before it may start its own transmission. Timing begins with a one-cycle start pulse that marks the falling edge of the last frame's acknowledge bit. The counter advances on a half-bit time-base tick of 1.2 ms, which is half of the 2.4 ms nominal data-bit period. The `free_done` flag rises once the required number of ticks has passed.

The wait length comes from a 3-bit configuration code that software owns. A nonzero code forces a fixed half-bit-granular length. Code 0 lets the timer choose the length from how the previous transfer ended. The length is captured when the start pulse arrives. Any falling edge on the bus after that point cancels the wait, and the timer stays idle until the next start pulse.

Top module: `cec_sft_timer`

## Requirements
- R1: After synchronous reset, `free_done` is low. Ticks that arrive before any start pulse leave it low.
- R2: A configuration code n in 1..7 selects a wait of 2n+1 ticks (1.5 to 7.5 bit periods).
- R3: With code 0, if any failure input is high (`arb_lost`, `tx_err`, `tx_underrun`, `ack_err`), the wait is 6 ticks (3 bit periods).
- R4: With code 0, no failure and `tx_ok` high, the wait is 14 ticks (7 bit periods).
- R5: With code 0, no failure and no `tx_ok`, the wait is 10 ticks (5 bit periods). This is the new-initiator case and also applies when no context input is high.
- R6: In automatic mode the context priority is failure, then successful completion, then new initiator.
- R7: `free_done` rises in the clock cycle that samples the tick reaching the selected count, and not one tick earlier. Clock cycles without a tick do not advance the count.
- R8: Once high, `free_done` stays high through further ticks, because the count saturates. It stays high until a start pulse or bus activity arrives.
- R9: A `bus_fall` without a start pulse clears the count and drops `free_done`. Ticks are then ignored until the next start pulse.
- R10: The wait length is latched at the start pulse. Changes to the code or the context inputs during the count do not alter it.
- R11: If `sft_start` and `bus_fall` are high in the same cycle, the start pulse wins and a new wait begins.
- R12: A start pulse that arrives mid-count or after completion restarts the wait from zero with a freshly selected length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sft_code | input | 3 | Wait-length code: 0 selects automatic, 1..7 select fixed lengths |
| sft_start | input | 1 | One-cycle pulse at the acknowledge bit's falling edge |
| bus_fall | input | 1 | One-cycle pulse on any falling edge seen on the bus |
| tick | input | 1 | Half-bit time-base pulse |
| arb_lost | input | 1 | Previous transfer lost arbitration |
| tx_err | input | 1 | Previous transfer had a transmit error |
| tx_underrun | input | 1 | Previous transfer ran out of data |
| ack_err | input | 1 | Previous transfer was not acknowledged |
| tx_ok | input | 1 | Previous transmission completed successfully |
| new_init | input | 1 | Node is about to act as a new initiator |
| free_done | output | 1 | Required free time has elapsed |

## Verification
The bench targets the exact tick on which the flag rises: it samples one tick before the selected count and again on that count. An off-by-one counter or a length formula that returned 2n in place of 2n+1 therefore fails on every code. It drives overlapping context inputs to expose a wrong priority, which would show up as a 10- or 14-tick wait where 6 is expected. It changes the code mid-count; a design that did not latch the length would finish at the wrong tick. It also checks that bus activity leaves the flag low through later ticks, that a start pulse wins over a simultaneous bus edge, and that the flag neither wraps nor drops during extra ticks.

// File: rtl/cec_sft_pkg.sv
package cec_sft_pkg;

    localparam int CODE_W = 3;
    localparam int CNT_W  = 4;

    typedef logic [CNT_W-1:0]  ticks_t;
    typedef logic [CODE_W-1:0] code_t;

    // Summary of how the previous transfer ended
    typedef struct packed {
        logic arb_lost;
        logic tx_err;
        logic underrun;
        logic ack_err;
        logic tx_ok;
        logic new_init;
    } xfer_ctx_t;

    typedef enum logic [1:0] {
        CTX_FAIL      = 2'd0,
        CTX_SUCCEEDED = 2'd1,
        CTX_INITIATOR = 2'd2
    } ctx_class_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_DONE  = 2'd2
    } sft_state_e;

    // Automatic-mode lengths in half-bit ticks
    localparam ticks_t AUTO_FAIL_TICKS = ticks_t'(6);
    localparam ticks_t AUTO_INIT_TICKS = ticks_t'(10);
    localparam ticks_t AUTO_OK_TICKS   = ticks_t'(14);

    // Code n is (n + 0.5) bit periods, which is 2n+1 half-bit ticks
    function automatic ticks_t fixed_ticks(input code_t c);
        return ticks_t'(2 * int'(c) + 1);
    endfunction

    function automatic ticks_t auto_ticks(input ctx_class_e k);
        case (k)
            CTX_FAIL:      return AUTO_FAIL_TICKS;
            CTX_SUCCEEDED: return AUTO_OK_TICKS;
            default:       return AUTO_INIT_TICKS;
        endcase
    endfunction

endpackage

// File: rtl/cec_sft_ctx_classify.sv
module cec_sft_ctx_classify
    import cec_sft_pkg::*;
(
    input  xfer_ctx_t  ctx,
    output ctx_class_e ctx_class
);

    logic any_fail;

    assign any_fail = ctx.arb_lost | ctx.tx_err | ctx.underrun | ctx.ack_err;

    // Failure outranks success, which outranks a new initiator
    always_comb begin
        if (any_fail)
            ctx_class = CTX_FAIL;
        else if (ctx.tx_ok)
            ctx_class = CTX_SUCCEEDED;
        else
            ctx_class = CTX_INITIATOR;
    end

endmodule

// File: rtl/cec_sft_len_sel.sv
module cec_sft_len_sel
    import cec_sft_pkg::*;
(
    input  code_t      code,
    input  ctx_class_e ctx_class,
    output ticks_t     wait_ticks
);

    always_comb begin
        if (code == '0)
            wait_ticks = auto_ticks(ctx_class);
        else
            wait_ticks = fixed_ticks(code);
    end

    // R2
    always_comb begin
        if (code != '0) begin
            len_range_chk: assert (wait_ticks >= ticks_t'(3) && wait_ticks[0] == 1'b1)
                else $error("fixed length out of range");
        end
    end

endmodule

// File: rtl/cec_sft_counter.sv
module cec_sft_counter
    import cec_sft_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   bus_fall,
    input  logic   tick,
    input  ticks_t new_len,
    output logic   done
);

    sft_state_e state;
    ticks_t     cnt;
    ticks_t     tgt;
    ticks_t     cnt_nxt;

    assign cnt_nxt = cnt + ticks_t'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            tgt   <= '0;
        end else if (start) begin
            // The start pulse wins over a simultaneous bus edge
            state <= ST_COUNT;
            cnt   <= '0;
            tgt   <= new_len;
        end else if (bus_fall) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else if (state == ST_COUNT && tick) begin
            cnt <= cnt_nxt;
            if (cnt_nxt == tgt)
                state <= ST_DONE;
        end
    end

    assign done = (state == ST_DONE);

    // R8
    sat_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_COUNT) |-> (cnt < tgt));

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !start && !bus_fall) |=> done);

    // R9
    clear_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_fall && !start) |=> (!done && state == ST_IDLE));

    // R12
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (!done && cnt == '0));

    // R7
    rise_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(tick));

    // R10
    len_held_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_COUNT && !start) |=> $stable(tgt));

endmodule

// File: rtl/cec_sft_timer.sv
module cec_sft_timer
    import cec_sft_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] sft_code,
    input  logic              sft_start,
    input  logic              bus_fall,
    input  logic              tick,
    input  logic              arb_lost,
    input  logic              tx_err,
    input  logic              tx_underrun,
    input  logic              ack_err,
    input  logic              tx_ok,
    input  logic              new_init,
    output logic              free_done
);

    xfer_ctx_t  ctx;
    ctx_class_e ctx_class;
    ticks_t     sel_len;

    always_comb begin
        ctx.arb_lost = arb_lost;
        ctx.tx_err   = tx_err;
        ctx.underrun = tx_underrun;
        ctx.ack_err  = ack_err;
        ctx.tx_ok    = tx_ok;
        ctx.new_init = new_init;
    end

    cec_sft_ctx_classify u_classify (
        .ctx       (ctx),
        .ctx_class (ctx_class)
    );

    cec_sft_len_sel u_len_sel (
        .code       (sft_code),
        .ctx_class  (ctx_class),
        .wait_ticks (sel_len)
    );

    cec_sft_counter u_counter (
        .clk      (clk),
        .rst      (rst),
        .start    (sft_start),
        .bus_fall (bus_fall),
        .tick     (tick),
        .new_len  (sel_len),
        .done     (free_done)
    );

    // R3
    auto_fail_chk: assert property (@(posedge clk) disable iff (rst)
        (sft_code == '0 && (arb_lost || tx_err || tx_underrun || ack_err))
            |-> (sel_len == ticks_t'(6)));

    // R6
    auto_ok_chk: assert property (@(posedge clk) disable iff (rst)
        (sft_code == '0 && !arb_lost && !tx_err && !tx_underrun && !ack_err && tx_ok)
            |-> (sel_len == ticks_t'(14)));

endmodule

// File: tb/tb_cec_sft_timer.sv
`timescale 1ns/1ps
module tb_cec_sft_timer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] sft_code = '0;
    logic       sft_start = 1'b0;
    logic       bus_fall = 1'b0;
    logic       tick = 1'b0;
    logic       arb_lost = 1'b0, tx_err = 1'b0, tx_underrun = 1'b0, ack_err = 1'b0;
    logic       tx_ok = 1'b0, new_init = 1'b0;
    logic       free_done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    cec_sft_timer dut (
        .clk(clk), .rst(rst), .sft_code(sft_code), .sft_start(sft_start),
        .bus_fall(bus_fall), .tick(tick), .arb_lost(arb_lost), .tx_err(tx_err),
        .tx_underrun(tx_underrun), .ack_err(ack_err), .tx_ok(tx_ok),
        .new_init(new_init), .free_done(free_done)
    );

    // vector: code[16:14] ctx[13:8] {arb,err,und,ackerr,ok,newi} pad[7:5] exp[4:0]
    localparam int NV = 17;
    localparam logic [16:0] VEC [0:NV-1] = '{
        {3'd1, 6'b000000, 3'd0, 5'd3},   // R2
        {3'd2, 6'b100000, 3'd0, 5'd5},   // R2 ctx ignored
        {3'd3, 6'b000010, 3'd0, 5'd7},   // R2
        {3'd4, 6'b000001, 3'd0, 5'd9},   // R2
        {3'd5, 6'b010000, 3'd0, 5'd11},  // R2
        {3'd6, 6'b000000, 3'd0, 5'd13},  // R2
        {3'd7, 6'b111111, 3'd0, 5'd15},  // R2
        {3'd0, 6'b100000, 3'd0, 5'd6},   // R3 arb lost
        {3'd0, 6'b010000, 3'd0, 5'd6},   // R3 tx error
        {3'd0, 6'b001000, 3'd0, 5'd6},   // R3 underrun
        {3'd0, 6'b000100, 3'd0, 5'd6},   // R3 ack error
        {3'd0, 6'b000010, 3'd0, 5'd14},  // R4
        {3'd0, 6'b000001, 3'd0, 5'd10},  // R5
        {3'd0, 6'b000000, 3'd0, 5'd10},  // R5 no context
        {3'd0, 6'b100010, 3'd0, 5'd6},   // R6 fail over ok
        {3'd0, 6'b000011, 3'd0, 5'd14},  // R6 ok over new initiator
        {3'd0, 6'b001101, 3'd0, 5'd6}    // R6 fail over new initiator
    };

    task automatic check(input logic got, input logic exp, input string req);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: free_done=%0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic set_ctx(input logic [5:0] c);
        {arb_lost, tx_err, tx_underrun, ack_err, tx_ok, new_init} = c;
    endtask

    task automatic do_start();
        sft_start = 1'b1;
        @(negedge clk);
        sft_start = 1'b0;
    endtask

    task automatic do_fall();
        bus_fall = 1'b1;
        @(negedge clk);
        bus_fall = 1'b0;
    endtask

    task automatic do_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            @(negedge clk);   // idle cycle: must not advance (R7)
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: cycles=%0d expected < 100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state and ticks without start
        check(free_done, 1'b0, "R1 reset");
        do_ticks(16);
        check(free_done, 1'b0, "R1 ticks before start");

        // Table walk: R2..R7, R8
        for (int v = 0; v < NV; v++) begin
            int exp_n;
            exp_n = int'(VEC[v][4:0]);
            sft_code = VEC[v][16:14];
            set_ctx(VEC[v][13:8]);
            do_start();
            sft_code = '0;
            set_ctx(6'b000000);
            do_ticks(exp_n - 1);
            check(free_done, 1'b0, $sformatf("R2-6/R7 vec %0d one tick early", v));
            do_ticks(1);
            check(free_done, 1'b1, $sformatf("R2-6/R7 vec %0d on count", v));
            do_ticks(3);
            check(free_done, 1'b1, $sformatf("R8 vec %0d saturated", v));
        end

        // R9: bus activity mid-count, then ticks ignored
        sft_code = 3'd1;
        do_start();
        do_ticks(2);
        do_fall();
        do_ticks(6);
        check(free_done, 1'b0, "R9 fall mid-count");
        // R9: bus activity after done
        do_start();
        do_ticks(3);
        check(free_done, 1'b1, "R9 setup done");
        do_fall();
        check(free_done, 1'b0, "R9 fall clears done");

        // R10: change code and context mid-count
        sft_code = 3'd2;
        do_start();
        sft_code = 3'd7;
        set_ctx(6'b000010);
        do_ticks(4);
        check(free_done, 1'b0, "R10 latched early");
        do_ticks(1);
        check(free_done, 1'b1, "R10 latched length 5");

        // R11: start and bus edge together
        sft_code = 3'd1;
        set_ctx(6'b000000);
        sft_start = 1'b1;
        bus_fall = 1'b1;
        @(negedge clk);
        sft_start = 1'b0;
        bus_fall = 1'b0;
        check(free_done, 1'b0, "R11 restart clears");
        do_ticks(3);
        check(free_done, 1'b1, "R11 start wins");

        // R12: restart mid-count with a different length
        sft_code = 3'd3;
        do_start();
        do_ticks(5);
        sft_code = 3'd2;
        do_start();
        do_ticks(4);
        check(free_done, 1'b0, "R12 restart from zero");
        do_ticks(1);
        check(free_done, 1'b1, "R12 new length 5");

        // R1: reset mid-count
        sft_code = 3'd1;
        do_start();
        do_ticks(2);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        do_ticks(3);
        check(free_done, 1'b0, "R1 reset cancels wait");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule